// File: doc/BRIEF.md
# Site Alarm Event Reporter

This block watches three digital field sensors at a remote site: a mains-power monitor, a tank-level switch and a valve-tamper switch. When any of them leaves its resting level, the block runs one reporting pass. It sounds a local buzzer and sends a single ASCII character for each active condition over an 8N1 serial transmit line, which feeds a wireless modem. It also shows which condition is on display through a 2-bit event code for an external display driver.

A pass visits the three conditions in a fixed order: power, then overflow, then theft. The set of active conditions is captured at the start of the pass. Each reported condition holds the display for its own hold period. After the last slot, a longer common hold-off runs, and then the buzzer goes quiet and the block re-arms. Inside the block, the sequencer hands characters to the serial transmitter over a valid/ready pair. The sequencer keeps `valid` and the character steady until `ready` accepts them, and the transmitter drops `ready` for the whole frame. That back-pressure is the only handshake in the block; the top-level pins are plain levels.

Top module: `site_alarm_reporter`

## Requirements
- R1: After reset the serial line is high, the buzzer is low and the event code is 0.
- R2: The resting levels are power sensor low, level sensor high and valve sensor high. While all three rest, no character is sent and the buzzer stays low.
- R3: A high power sensor is reported as the character 0x50 ('P'), and the event code reads 1 while it is on display.
- R4: A low level sensor is reported as the character 0x4F ('O'), and the event code reads 2 while it is on display.
- R5: A low valve sensor is reported as the character 0x54 ('T'), and the event code reads 3 while it is on display.
- R6: When several conditions are active, one character is sent for each, in the order power, overflow, theft. The event code never steps back to a lower nonzero value within a pass.
- R7: Each character is framed as one low start bit, eight data bits sent least significant bit first, and one high stop bit. Every bit lasts CLKS_PER_BIT cycles. The line is high whenever no frame is in progress.
- R8: The buzzer rises within 4 cycles of a sensor change, counting the two synchronizer flops. It stays high for N×(10×CLKS_PER_BIT + HOLD_CYCLES) + FINAL_CYCLES cycles plus at most 16 cycles of sequencing overhead, where N is the number of conditions reported in the pass.
- R9: Conditions are captured when a pass starts. A condition that appears during a pass is not reported in that pass.
- R10: If any condition is still active when a pass ends, a new pass starts and reports it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| power_sense | input | 1 | Mains sensor; high means power failure |
| level_sense | input | 1 | Tank-level switch; low means overflow |
| valve_sense | input | 1 | Valve switch; low means valve operated |
| uart_tx | output | 1 | 8N1 serial output toward the radio |
| buzzer | output | 1 | Local alarm buzzer |
| event_code | output | 2 | Condition on display: 0 none, 1 power, 2 overflow, 3 theft |

## Verification
A sensor change reaches the buzzer after three registers: two synchronizer flops and the sequencer state. The bench therefore allows at most 4 cycles for the buzzer to rise, and it measures that delay on falling clock edges. Each character's start bit follows within a few cycles. A serial monitor in the bench finds the start bit on a falling edge and samples every bit at its middle, so each bit is read CLKS_PER_BIT cycles after the previous one. The event code is read in the middle of the stop bit, when the character on the line is the one on display. The buzzer length is counted cycle by cycle and compared against the R8 formula, with up to 16 cycles allowed above it. Sensors are changed only after the buzzer has risen, which puts mid-pass changes on the far side of the capture point.

// File: rtl/site_alarm_pkg.sv
package site_alarm_pkg;
  localparam int NUM_COND = 3;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_POWER = 2'd1,
    EV_LEVEL = 2'd2,
    EV_VALVE = 2'd3
  } event_e;

  // resting levels: {valve, level, power}
  localparam logic [NUM_COND-1:0] REST_LEVELS = 3'b110;

  function automatic logic [7:0] slot_char(input logic [1:0] slot);
    case (slot)
      2'd0:    slot_char = 8'h50;
      2'd1:    slot_char = 8'h4F;
      default: slot_char = 8'h54;
    endcase
  endfunction
endpackage

// File: rtl/sensor_sync.sv
module sensor_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RESET_VAL;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/alarm_uart_tx.sv
module alarm_uart_tx #(
  parameter int CLKS_PER_BIT = 868
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       tx
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int FRAME_BITS = 10;

  logic          busy_q;
  logic [CW-1:0] tick_q;
  logic [3:0]    bit_q;
  logic [8:0]    shift_q;

  assign in_ready = !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      tick_q  <= '0;
      bit_q   <= '0;
      shift_q <= '1;
      tx      <= 1'b1;
    end else if (!busy_q) begin
      if (in_valid) begin
        busy_q  <= 1'b1;
        tick_q  <= '0;
        bit_q   <= '0;
        shift_q <= {1'b1, in_data};
        tx      <= 1'b0;
      end
    end else if (tick_q == CW'(CLKS_PER_BIT-1)) begin
      tick_q <= '0;
      if (bit_q == 4'(FRAME_BITS-1)) begin
        busy_q <= 1'b0;
        tx     <= 1'b1;
      end else begin
        bit_q   <= bit_q + 4'd1;
        tx      <= shift_q[0];
        shift_q <= {1'b1, shift_q[8:1]};
      end
    end else begin
      tick_q <= tick_q + CW'(1);
    end
  end

  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx) else $error("idle line low"); // R7
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> (in_valid && $stable(in_data))) else $error("offer dropped"); // R7
endmodule

// File: rtl/alarm_sequencer.sv
module alarm_sequencer
  import site_alarm_pkg::*;
#(
  parameter int HOLD_CYCLES = 25_000_000,
  parameter int FINAL_CYCLES = 50_000_000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_COND-1:0] alarm,
  output logic                out_valid,
  output logic [7:0]          out_data,
  input  logic                out_ready,
  output logic                buzzer,
  output logic [1:0]          event_code
);
  localparam int MAXC = (HOLD_CYCLES > FINAL_CYCLES) ? HOLD_CYCLES : FINAL_CYCLES;
  localparam int CNTW = $clog2(MAXC + 1);
  localparam logic [1:0] LAST_SLOT = 2'(NUM_COND-1);

  typedef enum logic [2:0] {S_IDLE, S_STEP, S_SEND, S_WAIT, S_HOLD, S_FINAL} st_e;

  st_e                 st_q;
  logic [NUM_COND-1:0] mask_q;
  logic [1:0]          slot_q;
  logic [CNTW-1:0]     cnt_q;

  assign out_valid = (st_q == S_SEND);
  assign out_data  = slot_char(slot_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      mask_q     <= '0;
      slot_q     <= '0;
      cnt_q      <= '0;
      buzzer     <= 1'b0;
      event_code <= EV_NONE;
    end else begin
      case (st_q)
        S_IDLE: if (|alarm) begin
          mask_q <= alarm;
          slot_q <= '0;
          buzzer <= 1'b1;
          st_q   <= S_STEP;
        end
        S_STEP: begin
          if (mask_q[slot_q]) begin
            event_code <= slot_q + 2'd1;
            st_q       <= S_SEND;
          end else if (slot_q == LAST_SLOT) begin
            cnt_q <= '0;
            st_q  <= S_FINAL;
          end else begin
            slot_q <= slot_q + 2'd1;
          end
        end
        S_SEND: if (out_ready) st_q <= S_WAIT;
        S_WAIT: if (out_ready) begin
          cnt_q <= '0;
          st_q  <= S_HOLD;
        end
        S_HOLD: begin
          if (cnt_q == CNTW'(HOLD_CYCLES-1)) begin
            event_code <= EV_NONE;
            cnt_q      <= '0;
            if (slot_q == LAST_SLOT) st_q <= S_FINAL;
            else begin
              slot_q <= slot_q + 2'd1;
              st_q   <= S_STEP;
            end
          end else cnt_q <= cnt_q + CNTW'(1);
        end
        S_FINAL: begin
          if (cnt_q == CNTW'(FINAL_CYCLES-1)) begin
            buzzer <= 1'b0;
            st_q   <= S_IDLE;
          end else cnt_q <= cnt_q + CNTW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_CODE_NEEDS_BUZZER: assert property (@(posedge clk) disable iff (rst)
    (event_code != 2'd0) |-> buzzer) else $error("code without buzzer"); // R8
  AST_CODE_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    ($past(event_code) != 2'd0 && event_code != 2'd0 && event_code != $past(event_code))
      |-> (event_code > $past(event_code))) else $error("order broken"); // R6
  AST_SEND_ONLY_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> mask_q[slot_q]) else $error("uncaptured send"); // R9
endmodule

// File: rtl/site_alarm_reporter.sv
module site_alarm_reporter
  import site_alarm_pkg::*;
#(
  parameter int CLKS_PER_BIT = 868,
  parameter int HOLD_CYCLES = 25_000_000,
  parameter int FINAL_CYCLES = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       power_sense,
  input  logic       level_sense,
  input  logic       valve_sense,
  output logic       uart_tx,
  output logic       buzzer,
  output logic [1:0] event_code
);
  logic [NUM_COND-1:0] raw, synced, alarm;
  logic                ch_valid, ch_ready;
  logic [7:0]          ch_data;

  assign raw = {valve_sense, level_sense, power_sense};

  sensor_sync #(.WIDTH(NUM_COND), .STAGES(2), .RESET_VAL(REST_LEVELS)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .dout(synced)
  );

  assign alarm = synced ^ REST_LEVELS;

  alarm_sequencer #(.HOLD_CYCLES(HOLD_CYCLES), .FINAL_CYCLES(FINAL_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .alarm(alarm),
    .out_valid(ch_valid), .out_data(ch_data), .out_ready(ch_ready),
    .buzzer(buzzer), .event_code(event_code)
  );

  alarm_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst(rst), .in_valid(ch_valid), .in_data(ch_data),
    .in_ready(ch_ready), .tx(uart_tx)
  );

  AST_QUIET_WHEN_REST: assert property (@(posedge clk) disable iff (rst)
    (!buzzer && $past(!buzzer) && alarm == '0) |=> !buzzer) else $error("spurious pass"); // R2
endmodule

// File: tb/site_alarm_reporter_tb_top.sv
`timescale 1ns/1ps
module site_alarm_reporter_tb_top;
  localparam int CPB = 4;
  localparam int HOLD = 24;
  localparam int FIN = 48;
  localparam int SLOT_LEN = 10*CPB + HOLD;

  logic clk = 0, rst = 1;
  logic p_s = 0, l_s = 1, v_s = 1;
  logic tx, buzz;
  logic [1:0] code;

  always #2 clk = ~clk;

  site_alarm_reporter #(.CLKS_PER_BIT(CPB), .HOLD_CYCLES(HOLD), .FINAL_CYCLES(FIN)) dut_i (
    .clk(clk), .rst(rst), .power_sense(p_s), .level_sense(l_s), .valve_sense(v_s),
    .uart_tx(tx), .buzzer(buzz), .event_code(code)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] rx_b [16];
  logic [1:0] rx_c [16];
  logic       rx_stop [16];
  int rx_n = 0, falls = 0, last_len = 0, cur_len = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin : rx_mon
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (!rst && tx === 1'b0) begin
        repeat (CPB/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = tx;
        end
        repeat (CPB) @(negedge clk);
        if (rx_n < 16) begin
          rx_b[rx_n] = b; rx_c[rx_n] = code; rx_stop[rx_n] = tx; rx_n++;
        end
      end
    end
  end

  initial begin : buzz_mon
    forever begin
      @(negedge clk);
      if (buzz) cur_len++;
      else if (cur_len != 0) begin
        last_len = cur_len; cur_len = 0; falls++;
      end
    end
  end

  task automatic clear_mon();
    rx_n = 0; falls = 0;
  endtask

  task automatic set_s(input logic p, input logic l, input logic v);
    @(negedge clk); p_s = p; l_s = l; v_s = v;
  endtask

  task automatic wait_falls(input int n);
    for (int i = 0; i < 5000 && falls < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic rise_delay(output int d);
    d = 0;
    while (!buzz && d < 50) begin @(negedge clk); d++; end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(tx === 1'b1, "R1 line", tx, 1);
    chk(buzz === 1'b0, "R1 buzzer", buzz, 0);
    chk(code === 2'd0, "R1 code", code, 0);
  endtask

  task automatic t_rest();
    clear_mon();
    repeat (200) @(negedge clk);
    chk(rx_n == 0, "R2 chars", rx_n, 0);
    chk(falls == 0 && !buzz, "R2 buzzer", buzz, 0);
  endtask

  task automatic t_single(input logic p, input logic l, input logic v,
                          input logic [7:0] ch, input int cd, input string req);
    int d;
    clear_mon();
    set_s(p, l, v);
    rise_delay(d);
    chk(d <= 4, "R8 rise delay", d, 4);
    set_s(0, 1, 1);
    wait_falls(1);
    chk(rx_n == 1, {req, " count"}, rx_n, 1);
    chk(rx_b[0] == ch, {req, " char"}, rx_b[0], ch);
    chk(rx_c[0] == cd, {req, " code"}, rx_c[0], cd);
    chk(rx_stop[0] == 1'b1, "R7 stop bit", rx_stop[0], 1);
    chk(last_len >= SLOT_LEN + FIN && last_len <= SLOT_LEN + FIN + 16,
        "R8 length", last_len, SLOT_LEN + FIN);
    chk(code == 0 && tx == 1, "R7 idle after", code, 0);
  endtask

  task automatic t_all();
    int d;
    clear_mon();
    set_s(1, 0, 0);
    rise_delay(d);
    set_s(0, 1, 1);
    wait_falls(1);
    chk(rx_n == 3, "R6 count", rx_n, 3);
    chk(rx_b[0] == 8'h50 && rx_b[1] == 8'h4F && rx_b[2] == 8'h54, "R6 order",
        rx_b[1], 8'h4F);
    chk(rx_c[0] == 1 && rx_c[1] == 2 && rx_c[2] == 3, "R6 codes", rx_c[2], 3);
    chk(last_len >= 3*SLOT_LEN + FIN && last_len <= 3*SLOT_LEN + FIN + 16,
        "R8 length three", last_len, 3*SLOT_LEN + FIN);
  endtask

  task automatic t_two();
    int d;
    clear_mon();
    set_s(1, 0, 1);
    rise_delay(d);
    set_s(0, 1, 1);
    wait_falls(1);
    chk(rx_n == 2 && rx_b[0] == 8'h50 && rx_b[1] == 8'h4F, "R6 pair", rx_b[1], 8'h4F);
    chk(last_len >= 2*SLOT_LEN + FIN && last_len <= 2*SLOT_LEN + FIN + 16,
        "R8 length two", last_len, 2*SLOT_LEN + FIN);
  endtask

  task automatic t_snapshot();
    int d;
    clear_mon();
    set_s(1, 1, 1);
    rise_delay(d);
    repeat (3) @(negedge clk);
    set_s(0, 1, 0);
    wait_falls(1);
    chk(rx_n == 1 && rx_b[0] == 8'h50, "R9 first pass", rx_b[0], 8'h50);
    rise_delay(d);
    set_s(0, 1, 1);
    wait_falls(2);
    chk(rx_n == 2 && rx_b[1] == 8'h54, "R9 next pass", rx_b[1], 8'h54);
  endtask

  task automatic t_rearm();
    clear_mon();
    set_s(1, 1, 1);
    wait_falls(2);
    chk(falls >= 2, "R10 passes", falls, 2);
    chk(rx_n >= 2 && rx_b[0] == 8'h50 && rx_b[1] == 8'h50, "R10 repeat", rx_n, 2);
    set_s(0, 1, 1);
    wait_falls(3);
    repeat (SLOT_LEN + FIN + 20) @(negedge clk);
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_rest();
    t_single(1, 1, 1, 8'h50, 1, "R3");
    t_single(0, 0, 1, 8'h4F, 2, "R4");
    t_single(0, 1, 0, 8'h54, 3, "R5");
    t_all();
    t_two();
    t_snapshot();
    t_rearm();
    t_rest();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule